// File: doc/BRIEF.md
# Host Bus Register Slave with Access Recovery Timing

This block is the slave end of an asynchronous host bus in the 80-series style. It has a 16-bit data path, a 3-bit address, and active-low chip select, read strobe and write strobe. The strobes and chip select are brought into an internal clock domain through two-flop synchronizers. That domain runs on a tick enable that divides the input clock by 1, 2, 4 or 8. One tick period is the internal period T.

An access is claimed on the synchronized falling edge of a strobe. Write data is taken when the write strobe rises. Once an access ends, a recovery counter holds `busy` high for a number of T periods that depends on the target:

| Access | Recovery |
|---|---|
| Quantization-table write | 3T |
| Quantization-table read | 7T |
| Code-buffer or thumbnail-buffer read | 4T |
| Any other access | 2T |

A strobe that falls while `busy` is high is dropped. It also sets a sticky violation flag.

Address 0 is a local configuration register. Its two low bits delay the internal chip select by 0 to 3 ticks, which relaxes address setup. Address 1 is the status word. Addresses 2 and up go out on a simple register port (`ext_*`) to the surrounding buffers and engines.

Top module: `hb_host_slave`

## Requirements
- R1: `div_sel` value s sets T to 2^s input clock cycles, for s = 0, 1, 2 and 3. Every recovery interval is a whole number of T periods.
- R2: A write to address 2 (quantization table) holds `busy` high for exactly 3T after the write ends.
- R3: A read of address 2 holds `busy` high for exactly 7T after the read ends.
- R4: A read of address 3 (code buffer) or address 4 (thumbnail buffer) holds `busy` high for exactly 4T.
- R5: Every other access holds `busy` high for exactly 2T. This covers any access to addresses 0, 1, 5, 6 or 7, and a write to address 3 or 4.
- R6: Write data is sampled from `din` when the write strobe rises, not when it falls. A write to address 0 loads the configuration word. A write to address 2 or higher gives one single-clock `ext_wr` pulse, with `ext_addr` and `ext_wdata` holding the address and the sampled data.
- R7: A read of address 0 returns the configuration word. A read of address 1 returns the violation flag in bit 0, with all other bits zero. A read of address 2 or higher returns `ext_rdata` sampled as the read strobe falls, and gives one single-clock `ext_rd` pulse. `dout_en` is high while a read is in progress.
- R8: Configuration bits [1:0] delay the synchronized chip select by that many ticks. A strobe falling edge seen while the delayed chip select is high is ignored: no data, no pulse, no recovery and no violation.
- R9: A strobe falling edge that arrives while `busy` is high is ignored, with no register change and no pulse. It sets `viol`, which stays set until reset.
- R10: After reset, `busy`, `viol`, `dout_en`, `ext_rd` and `ext_wr` are low, and `dout` and the configuration word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Divider select: T = 2^div_sel clock cycles |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| din | input | 16 | Write data from host |
| dout | output | 16 | Read data to host |
| dout_en | output | 1 | Read data drive enable |
| busy | output | 1 | Recovery interval active |
| viol | output | 1 | Sticky access-during-recovery flag |
| ext_rd | output | 1 | Read pulse to external register port |
| ext_wr | output | 1 | Write pulse to external register port |
| ext_addr | output | 3 | Address on external register port |
| ext_wdata | output | 16 | Write data on external register port |
| ext_rdata | input | 16 | Read data from external register port |

## Verification
The assertions assume two things about the host. First, it holds `addr` and `din` steady for several ticks around each strobe edge. Second, it never drives both strobes low together, so each falling edge starts at most one access.

The stimulus follows these rules. Every bus phase is several T long. Address and data change only while both strobes are high, except in the one deliberate write-data change before the write strobe rises. `div_sel` changes only when the bus is idle and `busy` is low. The only overlapping access is the deliberate one that tests the violation rule.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    ACC_OTHER  = 2'd0,
    ACC_QT_WR  = 2'd1,
    ACC_QT_RD  = 2'd2,
    ACC_BUF_RD = 2'd3
  } acc_kind_t;

  localparam int ADDR_CFG   = 0;
  localparam int ADDR_STAT  = 1;
  localparam int ADDR_QT    = 2;
  localparam int ADDR_CODE  = 3;
  localparam int ADDR_THUMB = 4;
endpackage

// File: rtl/hb_tick_gen.sv
module hb_tick_gen #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;
  localparam int CW1   = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  assign mask = CNT_W'((CW1'(1) << sel) - CW1'(1));
  assign tick = (cnt & mask) == mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + CNT_W'(1);
endmodule

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else if (en) begin
        s1 <= d[i];
        s2 <= s1;
      end
    assign q[i] = s2;
  end
endmodule

// File: rtl/hb_recovery.sv
module hb_recovery #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= '0;
    else if (tick) begin
      if (load)                cnt <= load_val;
      else if (cnt != '0)      cnt <= cnt - CW'(1);
    end

  assign busy = cnt != '0;
endmodule

// File: rtl/hb_host_slave.sv
module hb_host_slave
  import hb_pkg::*;
#(
  parameter int SEL_W      = 2,
  parameter int AW         = 3,
  parameter int DW         = 16,
  parameter int GAP_QT_WR  = 3,
  parameter int GAP_QT_RD  = 7,
  parameter int GAP_BUF_RD = 4,
  parameter int GAP_OTHER  = 2,
  parameter int CSDLY_MAX  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_en,
  output logic             busy,
  output logic             viol,
  output logic             ext_rd,
  output logic             ext_wr,
  output logic [AW-1:0]    ext_addr,
  output logic [DW-1:0]    ext_wdata,
  input  logic [DW-1:0]    ext_rdata
);
  localparam int GAP_A   = GAP_QT_WR > GAP_QT_RD ? GAP_QT_WR : GAP_QT_RD;
  localparam int GAP_B   = GAP_BUF_RD > GAP_OTHER ? GAP_BUF_RD : GAP_OTHER;
  localparam int GAP_MAX = GAP_A > GAP_B ? GAP_A : GAP_B;
  localparam int CW      = $clog2(GAP_MAX + 1);
  localparam int CSD_W   = $clog2(CSDLY_MAX + 1);

  function automatic acc_kind_t classify(input logic is_wr, input logic [AW-1:0] a);
    if (a == AW'(ADDR_QT))                                       return is_wr ? ACC_QT_WR : ACC_QT_RD;
    if (!is_wr && (a == AW'(ADDR_CODE) || a == AW'(ADDR_THUMB))) return ACC_BUF_RD;
    return ACC_OTHER;
  endfunction

  function automatic logic [CW-1:0] gap_of(input acc_kind_t k);
    case (k)
      ACC_QT_WR:  return CW'(GAP_QT_WR);
      ACC_QT_RD:  return CW'(GAP_QT_RD);
      ACC_BUF_RD: return CW'(GAP_BUF_RD);
      default:    return CW'(GAP_OTHER);
    endcase
  endfunction

  logic tick;
  hb_tick_gen #(.SEL_W(SEL_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel(div_sel), .tick(tick)
  );

  logic cs_s, rd_s, wr_s;
  hb_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(tick),
    .d({cs_n, rd_n, wr_n}), .q({cs_s, rd_s, wr_s})
  );

  // chip-select delay line, tap chosen by configuration
  logic [DW-1:0]        cfg;
  logic [CSDLY_MAX:1]   cs_dly;
  logic [CSDLY_MAX:0]   cs_tap;
  logic [CSD_W-1:0]     csdly;
  logic                 cs_int;
  assign cs_tap = {cs_dly, cs_s};
  assign csdly  = cfg[CSD_W-1:0];
  assign cs_int = cs_tap[csdly];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cs_dly <= '1;
    else if (tick) cs_dly <= cs_tap[CSDLY_MAX-1:0];

  logic rd_prev, wr_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_prev <= 1'b1;
      wr_prev <= 1'b1;
    end else if (tick) begin
      rd_prev <= rd_s;
      wr_prev <= wr_s;
    end

  // named internal events
  logic rd_fall_w, wr_fall_w, rd_rise_w, wr_rise_w;
  logic start_w, accept_w, viol_evt_w, end_w;
  logic pend, pend_wr;
  logic [AW-1:0] pend_addr;

  assign rd_fall_w  = tick & rd_prev & ~rd_s;
  assign wr_fall_w  = tick & wr_prev & ~wr_s;
  assign rd_rise_w  = tick & ~rd_prev & rd_s;
  assign wr_rise_w  = tick & ~wr_prev & wr_s;
  assign start_w    = (rd_fall_w | wr_fall_w) & ~cs_int & ~pend;
  assign viol_evt_w = start_w & busy;
  assign accept_w   = start_w & ~busy;
  assign end_w      = pend & (pend_wr ? wr_rise_w : rd_rise_w);

  hb_recovery #(.CW(CW)) u_rec (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(end_w),
    .load_val(gap_of(classify(pend_wr, pend_addr))), .busy(busy)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    if (addr == AW'(ADDR_CFG))       rd_mux = cfg;
    else if (addr == AW'(ADDR_STAT)) rd_mux = {{(DW-1){1'b0}}, viol};
    else                             rd_mux = ext_rdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_wr   <= 1'b0;
      pend_addr <= '0;
      cfg       <= '0;
      dout      <= '0;
      viol      <= 1'b0;
      ext_rd    <= 1'b0;
      ext_wr    <= 1'b0;
      ext_addr  <= '0;
      ext_wdata <= '0;
    end else begin
      ext_rd <= 1'b0;
      ext_wr <= 1'b0;
      if (viol_evt_w) viol <= 1'b1;
      if (accept_w) begin
        pend      <= 1'b1;
        pend_wr   <= wr_fall_w;
        pend_addr <= addr;
        ext_addr  <= addr;
        if (!wr_fall_w) begin
          dout   <= rd_mux;
          ext_rd <= addr >= AW'(ADDR_QT);
        end
      end else if (end_w) begin
        pend <= 1'b0;
        if (pend_wr) begin
          if (pend_addr == AW'(ADDR_CFG)) cfg <= din;
          else if (pend_addr >= AW'(ADDR_QT)) begin
            ext_wr    <= 1'b1;
            ext_wdata <= din;
          end
        end
      end
    end

  assign dout_en = pend & ~pend_wr;
endmodule

// File: rtl/hb_host_slave_chk.sv
module hb_host_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic viol,
  input logic ext_rd,
  input logic ext_wr,
  input logic dout_en,
  input logic end_evt
);
  AST_BUSY_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(end_evt)); // R5
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol); // R9
  AST_RD_NOT_DURING_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |-> !$past(busy)); // R9
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |=> !ext_wr); // R6
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_wr && ext_rd)); // R7
  AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !busy); // R7
endmodule

bind hb_host_slave hb_host_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .viol(viol), .ext_rd(ext_rd),
  .ext_wr(ext_wr), .dout_en(dout_en), .end_evt(end_w)
);

// File: tb/hb_host_slave_test.sv
module hb_host_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout, ext_wdata, ext_rdata;
  logic dout_en, busy, viol, ext_rd, ext_wr;
  logic [2:0] ext_addr;

  int n_chk = 0, n_fail = 0, T = 1;
  int wr_cnt = 0, rd_cnt = 0;
  logic [2:0] last_wa;
  logic [15:0] last_wd;
  bit done = 0;

  always #10 clk = ~clk;

  assign ext_rdata = 16'hC300 | {13'd0, addr};

  hb_host_slave uut (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .busy(busy), .viol(viol), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  always @(negedge clk) begin
    if (ext_wr) begin wr_cnt++; last_wa = ext_addr; last_wd = ext_wdata; end
    if (ext_rd) rd_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * T) @(negedge clk);
  endtask

  function automatic int gap_exp(input bit is_wr, input logic [2:0] a);
    if (a == 3'd2) return is_wr ? 3 : 7;
    if (!is_wr && (a == 3'd3 || a == 3'd4)) return 4;
    return 2;
  endfunction

  // one host access; returns read data and measured busy length in clocks
  task automatic host(input bit is_wr, input logic [2:0] a, input logic [15:0] d,
                      input int lead, output logic [15:0] rv, output int bcyc);
    int n;
    @(negedge clk);
    addr = a; din = d; cs_n = 1'b0;
    wait_ticks(lead);
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    wait_ticks(6);
    rv = dout;
    if (is_wr) wr_n = 1'b1; else rd_n = 1'b1;
    n = 0;
    while (!busy && n < 10 * T) begin @(negedge clk); n++; end
    bcyc = 0;
    while (busy && bcyc < 200) begin bcyc++; @(negedge clk); end
    cs_n = 1'b1;
    wait_ticks(2);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    int bc, w0, r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 busy", busy, 0);
    check("R10 viol", viol, 0);
    check("R10 dout_en", dout_en, 0);
    check("R10 dout", dout, 0);
    check("R10 pulses", {ext_rd, ext_wr}, 0);
    host(0, 3'd0, 0, 2, rv, bc);
    check("R10 cfg zero", rv, 0);

    // sweep divider settings and access kinds: R1..R7
    for (int s = 0; s < 4; s++) begin
      logic [15:0] v;
      div_sel = s[1:0];
      T = 1 << s;
      wait_ticks(4);
      v = 16'hA5C0 ^ (16'(s) << 8);
      host(1, 3'd0, v, 2, rv, bc);
      check("R5 R1 cfg write gap", bc, gap_exp(1, 3'd0) * T);
      host(0, 3'd0, 0, 2, rv, bc);
      check("R7 cfg read", rv, v);
      check("R5 R1 cfg read gap", bc, gap_exp(0, 3'd0) * T);
      w0 = wr_cnt;
      host(1, 3'd2, 16'h0F00 | 16'(s), 2, rv, bc);
      check("R2 R1 qt write gap", bc, 3 * T);
      check("R6 qt write pulse", wr_cnt - w0, 1);
      check("R6 qt write data", {13'd0, last_wa, last_wd}, {13'd0, 3'd2, 16'h0F00 | 16'(s)});
      r0 = rd_cnt;
      host(0, 3'd2, 0, 2, rv, bc);
      check("R3 R1 qt read gap", bc, 7 * T);
      check("R7 qt read data", rv, 16'hC302);
      check("R7 qt read pulse", rd_cnt - r0, 1);
      host(0, 3'd3, 0, 2, rv, bc);
      check("R4 R1 code read gap", bc, 4 * T);
      check("R7 code read data", rv, 16'hC303);
      host(0, 3'd4, 0, 2, rv, bc);
      check("R4 R1 thumb read gap", bc, 4 * T);
      host(1, 3'd3, 16'h1234, 2, rv, bc);
      check("R5 code write gap", bc, 2 * T);
      host(0, 3'd5, 0, 2, rv, bc);
      check("R5 addr5 read gap", bc, 2 * T);
      host(0, 3'd1, 0, 2, rv, bc);
      check("R7 status read", rv, 0);
      check("R5 status read gap", bc, 2 * T);
    end

    // R6: data sampled at write strobe rise
    div_sel = 2'd1; T = 2;
    wait_ticks(4);
    w0 = wr_cnt;
    @(negedge clk);
    addr = 3'd6; din = 16'h1111; cs_n = 1'b0;
    wait_ticks(2);
    wr_n = 1'b0;
    wait_ticks(6);
    din = 16'h2222;
    wait_ticks(2);
    wr_n = 1'b1;
    wait_ticks(12);
    cs_n = 1'b1;
    check("R6 rise sampled data", last_wd, 16'h2222);
    check("R6 rise addr", last_wa, 3'd6);
    check("R6 single pulse", wr_cnt - w0, 1);

    // R8: chip-select delay
    div_sel = 2'd0; T = 1;
    wait_ticks(4);
    host(1, 3'd0, 16'h0003, 6, rv, bc);
    r0 = rd_cnt;
    host(0, 3'd2, 0, 0, rv, bc);
    check("R8 late cs ignored gap", bc, 0);
    check("R8 late cs no pulse", rd_cnt - r0, 0);
    check("R8 late cs no viol", viol, 0);
    host(0, 3'd0, 0, 6, rv, bc);
    check("R8 early cs accepted", rv, 16'h0003);
    check("R8 early cs gap", bc, 2);
    host(1, 3'd0, 16'h1230, 6, rv, bc);
    host(0, 3'd0, 0, 0, rv, bc);
    check("R8 zero delay accepted", rv, 16'h1230);

    // R9: access during recovery
    div_sel = 2'd1; T = 2;
    wait_ticks(4);
    w0 = wr_cnt;
    @(negedge clk);
    addr = 3'd2; cs_n = 1'b0;
    wait_ticks(2);
    rd_n = 1'b0;
    wait_ticks(6);
    rd_n = 1'b1;
    wait_ticks(1);
    addr = 3'd2; din = 16'hBEE0; wr_n = 1'b0;
    wait_ticks(3);
    wr_n = 1'b1;
    wait_ticks(14);
    cs_n = 1'b1;
    wait_ticks(2);
    check("R9 viol set", viol, 1);
    check("R9 ignored write no pulse", wr_cnt - w0, 0);
    host(1, 3'd0, 16'h4440, 2, rv, bc);
    host(0, 3'd1, 0, 2, rv, bc);
    check("R9 viol sticky in status", rv, 1);
    check("R9 viol port sticky", viol, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule